// File: doc/BRIEF.md
# Hybrid Boolean Network Random Bit Source

This block is a physical random bit generator for programmable logic. Each lane holds a ring of unclocked three-input parity gates. Every gate combines its own output with the outputs of its two neighbours. One gate in each ring inverts its result, so the ring has no state in which it can rest. Free-running switching with uneven gate delays gives irregular, broadband transitions. A clocked stage captures four nodes spread evenly around the ring. Each capture passes through two flip-flops. The four settled samples are then XOR-combined into one registered bit per clock.

Several lanes are instantiated side by side and share no signals, so the block delivers a word of independent bits on every clock. A registered enable drives every gate output to zero while it is low, which holds the rings still. A valid strobe marks the output as usable only after a fixed warm-up count of clocks with enable high.

For simulation, a parameter replaces each gate by a model that re-evaluates after its own delay of 250 to 310 ps, so the rings switch inside a bench. With the default setting the rings are plain combinational loops. The ring size is 16 by default. It should not be set below 6, because smaller rings settle or merely oscillate.

Top module: `hbn_rng_array`

## Requirements
- R1: While reset is high, and on the first clock after it, every bit of `rnd_o` and `valid_o` is 0.
- R2: With WARMUP = 16, `valid_o` stays 0 for 17 rising edges after `en_i` is first seen high and becomes 1 on the 18th edge. The count restarts each time enable returns.
- R3: After `en_i` goes low, `valid_o` is still 1 at the first rising edge and is 0 from the second rising edge onward.
- R4: From the fourth rising edge after `en_i` goes low, every bit of `rnd_o` is 0 and stays 0 for as long as enable stays low.
- R5: While enabled, every lane of `rnd_o` takes both values 0 and 1 over 25,000 clocks.
- R6: While enabled, the fraction of ones over 100,000 output bits, pooled across the lanes, lies between 0.45 and 0.55.
- R7: While enabled, every pair of lanes disagrees in at least 25 percent of 25,000 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds every ring at zero |
| rnd_o | output | LANES | One registered random bit per lane |
| valid_o | output | 1 | High once the warm-up count has elapsed with enable held |

## Verification
The enable input is driven through a table of phases: a first warm-up, a release, a long hold at zero, and a second warm-up. These phases separate the warm-up length, the delay before valid drops, and the flush of the sampling pipeline to zero. Once valid is high, a long free-running stretch tests each lane for a stuck output, for the pooled ones fraction, and for pairwise disagreement between lanes. Together these checks tell a working ring apart from a dead one, a biased one, or lanes that copy one another.

// File: rtl/hbn_pkg.sv
`timescale 1ps/1ps
package hbn_pkg;

  // Node index of capture point k when TAPS points are spread over N nodes
  function automatic int tap_index(input int k, input int n, input int taps);
    return (k * n) / taps;
  endfunction

  // Per-gate simulation delay in ps, distinct inside one ring (13 is invertible mod 61)
  function automatic int gate_delay_ps(input int lane, input int node);
    return 250 + ((node * 13 + lane * 29 + 7) % 61);
  endfunction

endpackage

// File: rtl/hbn_ring.sv
`timescale 1ps/1ps
module hbn_ring #(
  parameter int N         = 16,
  parameter int LANE      = 0,
  parameter int SIM_MODEL = 0
) (
  input  logic         run_i,
  output logic [N-1:0] node_o
);

  for (genvar i = 0; i < N; i++) begin : g_node
    localparam int   LEFT = (i + N - 1) % N;
    localparam int   RIGHT = (i + 1) % N;
    localparam logic INV = (i == 0);
    logic parity;
    assign parity = node_o[LEFT] ^ node_o[i] ^ node_o[RIGHT] ^ INV;

    if (SIM_MODEL != 0) begin : g_sim
      localparam int DLY = hbn_pkg::gate_delay_ps(LANE, i);
      logic q = 1'b0;
      always begin
        #(DLY);
        q <= run_i & parity;
      end
      assign node_o[i] = q;
    end else begin : g_hw
      assign node_o[i] = run_i & parity;
    end
  end

endmodule

// File: rtl/hbn_sampler.sv
`timescale 1ps/1ps
module hbn_sampler #(
  parameter int TAPS = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [TAPS-1:0] tap_i,
  output logic            bit_o
);

  logic [TAPS-1:0] meta_q;
  logic [TAPS-1:0] sync_q;
  logic            bit_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '0;
      sync_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      meta_q <= tap_i;
      sync_q <= meta_q;
      bit_q  <= ^sync_q;
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/hbn_warmup.sv
`timescale 1ps/1ps
module hbn_warmup #(
  parameter int WARMUP = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic valid_o
);

  localparam int CW = $clog2(WARMUP + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WARMUP);

  logic [CW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (!en_i)              cnt_q <= '0;
      else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
      valid_q <= en_i && (cnt_q == LIMIT);
    end
  end

  assign valid_o = valid_q;

  a_r2_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LIMIT);

  a_r2_rise_at_count: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(valid_q) |-> ($past(cnt_q) == LIMIT));

  a_r3_valid_needs_enable: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_q |-> $past(en_i));

endmodule

// File: rtl/hbn_rng_array.sv
`timescale 1ps/1ps
module hbn_rng_array #(
  parameter int LANES     = 4,
  parameter int RING_N    = 16,
  parameter int TAPS      = 4,
  parameter int WARMUP    = 16,
  parameter int SIM_MODEL = 0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [LANES-1:0] rnd_o,
  output logic             valid_o
);

  logic en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= en_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [RING_N-1:0] nodes;
    logic [TAPS-1:0]   taps;

    hbn_ring #(.N(RING_N), .LANE(l), .SIM_MODEL(SIM_MODEL)) u_ring (
      .run_i (en_q),
      .node_o(nodes)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign taps[k] = nodes[hbn_pkg::tap_index(k, RING_N, TAPS)];
    end

    hbn_sampler #(.TAPS(TAPS)) u_sampler (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .tap_i(taps),
      .bit_o(rnd_o[l])
    );
  end

  hbn_warmup #(.WARMUP(WARMUP)) u_warmup (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_q),
    .valid_o(valid_o)
  );

  a_r4_quiet_when_held: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(en_q) && !$past(en_q, 2) && !$past(en_q, 3)) |-> (rnd_o == '0));

endmodule

// File: tb/hbn_rng_array_bench.sv
`timescale 1ps/1ps
module hbn_rng_array_bench;

  localparam int LANES = 4;
  localparam int STAT_CYCLES = 25000;

  logic             clk = 1'b0;
  logic             rst;
  logic             en;
  logic [LANES-1:0] rnd;
  logic             valid;

  int checks = 0;
  int fails  = 0;

  always #2000 clk = ~clk;

  hbn_rng_array #(.LANES(LANES), .RING_N(16), .TAPS(4), .WARMUP(16), .SIM_MODEL(1)) u_hbn_rng_array (
    .clk_i  (clk),
    .rst_i  (rst),
    .en_i   (en),
    .rnd_o  (rnd),
    .valid_o(valid)
  );

  // columns: enable, rising edges to run, expected valid, expect all-zero output
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{1, 17, 0, 0},   // R2 not yet valid
    '{1,  1, 1, 0},   // R2 valid on 18th edge
    '{0,  1, 1, 0},   // R3 still high one edge after release
    '{0,  1, 0, 0},   // R3 low on second edge
    '{0,  2, 0, 1},   // R4 output flushed by fourth edge
    '{0, 20, 0, 1},   // R4 stays zero while held
    '{1, 17, 0, 0},   // R2 count restarts
    '{1,  1, 1, 0}    // R2 valid again
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #800000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    en  = 1'b0;
    step(3);
    check(rnd == '0, "R1 rnd in reset", int'(rnd), 0);
    check(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    rst = 1'b0;
    step(1);
    check(rnd == '0 && valid == 1'b0, "R1 after reset", int'({valid, rnd}), 0);

    for (int v = 0; v < NV; v++) begin
      en = VEC[v][0][0];
      step(VEC[v][1]);
      check(valid == VEC[v][2][0], $sformatf("R2/R3 valid row %0d", v), int'(valid), VEC[v][2]);
      if (VEC[v][3] != 0)
        check(rnd == '0, $sformatf("R4 held output row %0d", v), int'(rnd), 0);
    end

    begin
      int ones = 0;
      int seen0 [LANES];
      int seen1 [LANES];
      int diff [LANES][LANES];
      for (int a = 0; a < LANES; a++) begin
        seen0[a] = 0;
        seen1[a] = 0;
        for (int b = 0; b < LANES; b++) diff[a][b] = 0;
      end
      for (int c = 0; c < STAT_CYCLES; c++) begin
        step(1);
        for (int a = 0; a < LANES; a++) begin
          if (rnd[a]) begin ones++; seen1[a]++; end
          else seen0[a]++;
          for (int b = a + 1; b < LANES; b++)
            if (rnd[a] != rnd[b]) diff[a][b]++;
        end
      end
      for (int a = 0; a < LANES; a++)
        check(seen0[a] > 0 && seen1[a] > 0, $sformatf("R5 lane %0d not stuck", a),
              seen1[a], STAT_CYCLES / 2);
      check(ones >= 45000 && ones <= 55000, "R6 ones fraction", ones, 50000);
      for (int a = 0; a < LANES; a++)
        for (int b = a + 1; b < LANES; b++)
          check(diff[a][b] >= STAT_CYCLES / 4, $sformatf("R7 lanes %0d/%0d differ", a, b),
                diff[a][b], STAT_CYCLES / 2);
      check(valid == 1'b1, "R2 valid held while enabled", int'(valid), 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule